// File: doc/BRIEF.md
# Dispatch Group Admission Controller

This block sits between an in-order queue of decoded instructions and the out-of-order back end. Each cycle it looks at the oldest `MAX_W` queue entries and decides how many of them, counted from the oldest, join this cycle's dispatch group. An instruction is admitted only if the group stays within the dispatch width and every back-end pool it draws from still has room: reorder-buffer entries, physical rename registers, entries in its target scheduler queue, and a load-queue or store-queue slot. Pool occupancy is tracked outside the block. The block receives each pool's free count and accounts internally for what older members of the same group have already claimed.

The admission decision is combinational, so the queue can pop `disp_cnt` entries and the pools can debit their credits at the same clock edge. When a cycle ends without a full group, the block reports one stall cause, chosen by a fixed priority. Two sets of registered counters record the results: one counts cycles per stall cause, and a histogram counts cycles by the number of micro-ops dispatched.

Top module: `dispatch_admit`

## Requirements
- R1: Admission is in order. `disp_vec` is always a run of ones starting at slot 0 (slot 0 is the oldest), and `disp_cnt` equals its length. A slot that is not valid ends the group, and a blocked instruction blocks every younger slot, even one that would fit.
- R2: The micro-op total of the group never exceeds the effective width. The exception is an instruction whose own micro-op count exceeds the width: it is admitted when it is slot 0 and its resources are available, and it then forms the whole group. Each valid slot carries 1 to 7 micro-ops.
- R3: An instruction is admitted only if the micro-ops of the group, up to and including its own, fit in `rob_free`.
- R4: An instruction is admitted only if the destination registers of the group, up to and including its own, fit in `reg_free`. When `reg_pool_size` is zero, the register pool is unbounded, and `reg_free` has no effect on admission.
- R5: `slot_sched` selects the scheduler for each slot, and the scheduler's free count sits at bits `[s*CRED_W +: CRED_W]` of `sched_free`. An instruction is admitted only if the group's micro-ops bound for its scheduler fit in that count. Each load (`slot_load`) takes one load-queue slot from `lq_free`, and each store (`slot_store`) takes one store-queue slot from `sq_free`.
- R6: `stall_cause` encodes 0 as none, 1 as rename registers short, 2 as reorder-buffer entries short, 3 as scheduler full, 4 as load queue full, 5 as store queue full and 6 as group width limit. The code describes the oldest instruction that was not admitted. When that instruction fails several checks, the lowest nonzero code wins. The code is 0 if the dispatched micro-ops reach the width, or if the oldest slot that was not admitted is not valid.
- R7: The stall counter for cause c (c = 1..6) sits at bits `[(c-1)*CNT_W +: CNT_W]` of `stall_cnt`. It increments by one at every clock edge where `stall_cause` equals c, and holds its value otherwise.
- R8: Histogram bin k sits at bits `[k*CNT_W +: CNT_W]` of `uop_hist`. At every clock edge, the block increments bin min(`disp_uops`, `MAX_W`) by one.
- R9: `cfg_width` of zero selects the width `DEFAULT_W`. A value above `MAX_W` is clamped to `MAX_W`. Any other value is used as given.
- R10: While `rst_n` is low, all stall counters and histogram bins read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_width | input | WCFG_W | Configured dispatch width (0 selects the default) |
| reg_pool_size | input | CRED_W | Rename pool size (0 means unbounded) |
| slot_valid | input | MAX_W | Queue entry present, per slot (slot 0 is the oldest) |
| slot_uops | input | MAX_W*UOP_W | Micro-op count per slot |
| slot_ndst | input | MAX_W*DST_W | Destination register count per slot |
| slot_sched | input | MAX_W*SID_W | Target scheduler per slot |
| slot_load | input | MAX_W | Slot is a load |
| slot_store | input | MAX_W | Slot is a store |
| rob_free | input | CRED_W | Free reorder-buffer entries |
| reg_free | input | CRED_W | Free rename registers |
| sched_free | input | N_SCHED*CRED_W | Free entries per scheduler |
| lq_free | input | CRED_W | Free load-queue entries |
| sq_free | input | CRED_W | Free store-queue entries |
| disp_vec | output | MAX_W | Dispatch strobe per slot |
| disp_cnt | output | WCFG_W | Instructions dispatched this cycle |
| disp_uops | output | SUM_W | Micro-ops dispatched this cycle |
| stall_cause | output | 3 | Stall cause code for this cycle |
| stall_cnt | output | 6*CNT_W | Per-cause stall cycle counters |
| uop_hist | output | (MAX_W+1)*CNT_W | Histogram of dispatched micro-ops per cycle |

## Verification
Two things can land on the same instruction in the same cycle: the group-width limit and running out of pool credits. Any of the pools can also run short together. Directed windows set up these overlaps on purpose, for example an instruction that overflows the width while the reorder buffer is also short, or a load-and-store that finds both queues full. The reported code must then follow the priority order, and the matching stall counter must advance at the next edge. A random stream with small credit pools then creates these coincidences often, and every cycle is compared against a behavioural model, including the oversize instruction that forms a group alone.

// File: rtl/dga_pkg.sv
package dga_pkg;

  localparam int NUM_CAUSES = 6;

  typedef enum logic [2:0] {
    CAUSE_NONE  = 3'd0,
    CAUSE_REG   = 3'd1,
    CAUSE_ROB   = 3'd2,
    CAUSE_SCHED = 3'd3,
    CAUSE_LQ    = 3'd4,
    CAUSE_SQ    = 3'd5,
    CAUSE_GROUP = 3'd6
  } stall_cause_e;

endpackage

// File: rtl/dga_slot_check.sv
// Checks one queue slot against the pools, given what older group members already claimed.
module dga_slot_check
  import dga_pkg::*;
#(
  parameter int UOP_W  = 3,
  parameter int DST_W  = 2,
  parameter int CRED_W = 6,
  parameter int SUM_W  = 7
) (
  input  logic              valid,
  input  logic [UOP_W-1:0]  uops,
  input  logic [DST_W-1:0]  ndst,
  input  logic              is_load,
  input  logic              is_store,
  input  logic [SUM_W-1:0]  uop_before,
  input  logic [SUM_W-1:0]  reg_before,
  input  logic [SUM_W-1:0]  sched_before,
  input  logic [SUM_W-1:0]  lq_before,
  input  logic [SUM_W-1:0]  sq_before,
  input  logic [SUM_W-1:0]  width,
  input  logic [CRED_W-1:0] rob_cap,
  input  logic [CRED_W-1:0] reg_cap,
  input  logic [CRED_W-1:0] sched_cap,
  input  logic [CRED_W-1:0] lq_cap,
  input  logic [CRED_W-1:0] sq_cap,
  input  logic              reg_unbounded,
  output logic              ok,
  output stall_cause_e      cause
);

  logic [SUM_W-1:0] uop_after;
  logic [SUM_W-1:0] reg_after;
  logic [SUM_W-1:0] sched_after;
  logic miss_reg, miss_rob, miss_sched, miss_lq, miss_sq, miss_grp;

  always_comb begin
    uop_after   = uop_before + SUM_W'(uops);
    reg_after   = reg_before + SUM_W'(ndst);
    sched_after = sched_before + SUM_W'(uops);
    miss_reg    = !reg_unbounded && (reg_after > SUM_W'(reg_cap));
    miss_rob    = uop_after > SUM_W'(rob_cap);
    miss_sched  = sched_after > SUM_W'(sched_cap);
    miss_lq     = is_load && (lq_before >= SUM_W'(lq_cap));
    miss_sq     = is_store && (sq_before >= SUM_W'(sq_cap));
    // an oversize instruction may still open an empty group (R2)
    miss_grp    = (uop_before != '0) && (uop_after > width);
  end

  // fixed priority among causes (R6)
  always_comb begin
    if (!valid)          cause = CAUSE_NONE;
    else if (miss_reg)   cause = CAUSE_REG;
    else if (miss_rob)   cause = CAUSE_ROB;
    else if (miss_sched) cause = CAUSE_SCHED;
    else if (miss_lq)    cause = CAUSE_LQ;
    else if (miss_sq)    cause = CAUSE_SQ;
    else if (miss_grp)   cause = CAUSE_GROUP;
    else                 cause = CAUSE_NONE;
    ok = valid && (cause == CAUSE_NONE);
  end

endmodule

// File: rtl/dga_stats.sv
// Per-cause stall counters and dispatched micro-op histogram.
module dga_stats
  import dga_pkg::*;
#(
  parameter int MAX_W = 4,
  parameter int CNT_W = 16,
  parameter int SUM_W = 7
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [2:0]                   cause_in,
  input  logic [SUM_W-1:0]             uops_in,
  output logic [NUM_CAUSES*CNT_W-1:0]  stall_cnt,
  output logic [(MAX_W+1)*CNT_W-1:0]   uop_hist
);

  logic [NUM_CAUSES-1:0][CNT_W-1:0] stall_q;
  logic [NUM_CAUSES-1:0][CNT_W-1:0] stall_d;
  logic [NUM_CAUSES-1:0]            stall_en;
  logic [MAX_W:0][CNT_W-1:0]        hist_q;
  logic [MAX_W:0][CNT_W-1:0]        hist_d;
  logic [MAX_W:0]                   hist_en;

  always_comb begin
    for (int c = 0; c < NUM_CAUSES; c++) begin
      stall_en[c] = (cause_in == 3'(c + 1));
      stall_d[c]  = stall_q[c] + CNT_W'(1);
    end
    for (int b = 0; b <= MAX_W; b++) begin
      if (b == MAX_W) hist_en[b] = (uops_in >= SUM_W'(MAX_W));
      else            hist_en[b] = (uops_in == SUM_W'(b));
      hist_d[b] = hist_q[b] + CNT_W'(1);
    end
  end

  for (genvar c = 0; c < NUM_CAUSES; c++) begin : g_stall
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           stall_q[c] <= '0;
      else if (stall_en[c]) stall_q[c] <= stall_d[c];
    end

    // R7: counter advances exactly on its own cause
    a_r7_cause_count: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_in == 3'(c + 1)) |=> (stall_q[c] == $past(stall_q[c]) + CNT_W'(1)));
    a_r7_cause_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_in != 3'(c + 1)) |=> $stable(stall_q[c]));
  end

  for (genvar b = 0; b <= MAX_W; b++) begin : g_hist
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          hist_q[b] <= '0;
      else if (hist_en[b]) hist_q[b] <= hist_d[b];
    end
  end

  // R8: exactly one bin selected per cycle
  a_r8_one_bin: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hist_en) && (hist_en != '0));

  assign stall_cnt = stall_q;
  assign uop_hist  = hist_q;

endmodule

// File: rtl/dispatch_admit.sv
module dispatch_admit
  import dga_pkg::*;
#(
  parameter int MAX_W     = 4,
  parameter int DEFAULT_W = 2,
  parameter int N_SCHED   = 2,
  parameter int UOP_W     = 3,
  parameter int DST_W     = 2,
  parameter int CRED_W    = 6,
  parameter int CNT_W     = 16,
  localparam int SID_W    = (N_SCHED > 1) ? $clog2(N_SCHED) : 1,
  localparam int WCFG_W   = $clog2(MAX_W + 1),
  localparam int SUM_W    = ((CRED_W > UOP_W + WCFG_W) ? CRED_W : (UOP_W + WCFG_W)) + 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [WCFG_W-1:0]             cfg_width,
  input  logic [CRED_W-1:0]             reg_pool_size,
  input  logic [MAX_W-1:0]              slot_valid,
  input  logic [MAX_W*UOP_W-1:0]        slot_uops,
  input  logic [MAX_W*DST_W-1:0]        slot_ndst,
  input  logic [MAX_W*SID_W-1:0]        slot_sched,
  input  logic [MAX_W-1:0]              slot_load,
  input  logic [MAX_W-1:0]              slot_store,
  input  logic [CRED_W-1:0]             rob_free,
  input  logic [CRED_W-1:0]             reg_free,
  input  logic [N_SCHED*CRED_W-1:0]     sched_free,
  input  logic [CRED_W-1:0]             lq_free,
  input  logic [CRED_W-1:0]             sq_free,
  output logic [MAX_W-1:0]              disp_vec,
  output logic [WCFG_W-1:0]             disp_cnt,
  output logic [SUM_W-1:0]              disp_uops,
  output logic [2:0]                    stall_cause,
  output logic [NUM_CAUSES*CNT_W-1:0]   stall_cnt,
  output logic [(MAX_W+1)*CNT_W-1:0]    uop_hist
);

  logic [SUM_W-1:0] width_eff;
  logic             reg_unbounded;

  // R9: width selection
  always_comb begin
    if (cfg_width == '0)                     width_eff = SUM_W'(DEFAULT_W);
    else if (cfg_width > WCFG_W'(MAX_W))     width_eff = SUM_W'(MAX_W);
    else                                     width_eff = SUM_W'(cfg_width);
  end
  assign reg_unbounded = (reg_pool_size == '0);

  // running claims of older slots, assuming every older slot joins the group
  logic [SUM_W-1:0] uop_pre [MAX_W+1];
  logic [SUM_W-1:0] reg_pre [MAX_W];
  logic [SUM_W-1:0] lq_pre  [MAX_W];
  logic [SUM_W-1:0] sq_pre  [MAX_W];
  logic [SUM_W-1:0] sch_pre [MAX_W][N_SCHED];

  logic [MAX_W-1:0] slot_ok;
  logic [MAX_W-1:0] admit;
  logic [MAX_W-1:0] older_in;
  stall_cause_e     slot_cause [MAX_W];

  assign uop_pre[0] = '0;
  assign reg_pre[0] = '0;
  assign lq_pre[0]  = '0;
  assign sq_pre[0]  = '0;
  for (genvar s = 0; s < N_SCHED; s++) begin : g_sch0
    assign sch_pre[0][s] = '0;
  end

  for (genvar g = 0; g < MAX_W; g++) begin : g_slot
    logic [UOP_W-1:0]  u;
    logic [DST_W-1:0]  nd;
    logic [SID_W-1:0]  sid;
    logic [SUM_W-1:0]  sch_before;
    logic [CRED_W-1:0] sch_cap;

    assign u          = slot_uops[g*UOP_W +: UOP_W];
    assign nd         = slot_ndst[g*DST_W +: DST_W];
    assign sid        = slot_sched[g*SID_W +: SID_W];
    assign sch_before = sch_pre[g][sid];
    assign sch_cap    = sched_free[sid*CRED_W +: CRED_W];

    assign uop_pre[g+1] = uop_pre[g] + SUM_W'(u);
    if (g < MAX_W - 1) begin : g_acc
      assign reg_pre[g+1] = reg_pre[g] + SUM_W'(nd);
      assign lq_pre[g+1]  = lq_pre[g] + SUM_W'(slot_load[g]);
      assign sq_pre[g+1]  = sq_pre[g] + SUM_W'(slot_store[g]);
      for (genvar s = 0; s < N_SCHED; s++) begin : g_sch
        assign sch_pre[g+1][s] = sch_pre[g][s] + ((sid == SID_W'(s)) ? SUM_W'(u) : '0);
      end
    end

    dga_slot_check #(
      .UOP_W (UOP_W),
      .DST_W (DST_W),
      .CRED_W(CRED_W),
      .SUM_W (SUM_W)
    ) u_check (
      .valid        (slot_valid[g]),
      .uops         (u),
      .ndst         (nd),
      .is_load      (slot_load[g]),
      .is_store     (slot_store[g]),
      .uop_before   (uop_pre[g]),
      .reg_before   (reg_pre[g]),
      .sched_before (sch_before),
      .lq_before    (lq_pre[g]),
      .sq_before    (sq_pre[g]),
      .width        (width_eff),
      .rob_cap      (rob_free),
      .reg_cap      (reg_free),
      .sched_cap    (sch_cap),
      .lq_cap       (lq_free),
      .sq_cap       (sq_free),
      .reg_unbounded(reg_unbounded),
      .ok           (slot_ok[g]),
      .cause        (slot_cause[g])
    );

    // R1: a slot joins only behind an unbroken run of admitted older slots
    if (g == 0) begin : g_head
      assign older_in[g] = 1'b1;
    end else begin : g_tail
      assign older_in[g] = admit[g-1];
    end
    assign admit[g] = slot_ok[g] && older_in[g];
  end

  stall_cause_e first_cause;

  always_comb begin
    disp_cnt    = '0;
    disp_uops   = '0;
    first_cause = CAUSE_NONE;
    for (int i = 0; i < MAX_W; i++) begin
      if (admit[i]) begin
        disp_cnt  = WCFG_W'(i + 1);
        disp_uops = uop_pre[i+1];
      end
      if (older_in[i] && !admit[i]) first_cause = slot_cause[i];
    end
    // R6: a full group is never a stall
    stall_cause = (disp_uops >= width_eff) ? 3'(CAUSE_NONE) : 3'(first_cause);
  end

  assign disp_vec = admit;

  dga_stats #(
    .MAX_W(MAX_W),
    .CNT_W(CNT_W),
    .SUM_W(SUM_W)
  ) u_stats (
    .clk      (clk),
    .rst_n    (rst_n),
    .cause_in (stall_cause),
    .uops_in  (disp_uops),
    .stall_cnt(stall_cnt),
    .uop_hist (uop_hist)
  );

  for (genvar g = 1; g < MAX_W; g++) begin : g_chk_order
    a_r1_prefix: assert property (@(posedge clk) disable iff (!rst_n)
      disp_vec[g] |-> disp_vec[g-1]);
  end

  a_r2_width: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_cnt > WCFG_W'(1)) |-> (disp_uops <= width_eff));

  a_r3_rob: assert property (@(posedge clk) disable iff (!rst_n)
    disp_uops <= SUM_W'(rob_free));

  a_r5_loads: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(disp_vec & slot_load) <= int'(lq_free));

  a_r5_stores: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(disp_vec & slot_store) <= int'(sq_free));

  a_r6_stall_room: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_cause != 3'(CAUSE_NONE)) |-> (disp_uops < width_eff));

endmodule

// File: tb/tb_dispatch_admit.sv
module tb_dispatch_admit;
  localparam int CLK_P   = 10;
  localparam int MAXW    = 4;
  localparam int DEFW    = 2;
  localparam int NS      = 2;
  localparam int CW      = 6;
  localparam int CNTW    = 16;
  localparam int ROB_CAP = 16;
  localparam int REG_CAP = 12;
  localparam int SCH_CAP = 8;
  localparam int LQ_CAP  = 4;
  localparam int SQ_CAP  = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic [2:0]        cfg_width;
  logic [CW-1:0]     reg_pool_size;
  logic [3:0]        slot_valid;
  logic [11:0]       slot_uops;
  logic [7:0]        slot_ndst;
  logic [3:0]        slot_sched;
  logic [3:0]        slot_load;
  logic [3:0]        slot_store;
  logic [CW-1:0]     rob_free, reg_free, lq_free, sq_free;
  logic [2*CW-1:0]   sched_free;
  logic [3:0]        disp_vec;
  logic [2:0]        disp_cnt;
  logic [6:0]        disp_uops;
  logic [2:0]        stall_cause;
  logic [6*CNTW-1:0] stall_cnt;
  logic [5*CNTW-1:0] uop_hist;

  dispatch_admit #(.MAX_W(MAXW), .DEFAULT_W(DEFW), .N_SCHED(NS), .UOP_W(3),
                   .DST_W(2), .CRED_W(CW), .CNT_W(CNTW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .reg_pool_size(reg_pool_size),
    .slot_valid(slot_valid), .slot_uops(slot_uops), .slot_ndst(slot_ndst),
    .slot_sched(slot_sched), .slot_load(slot_load), .slot_store(slot_store),
    .rob_free(rob_free), .reg_free(reg_free), .sched_free(sched_free),
    .lq_free(lq_free), .sq_free(sq_free), .disp_vec(disp_vec), .disp_cnt(disp_cnt),
    .disp_uops(disp_uops), .stall_cause(stall_cause), .stall_cnt(stall_cnt),
    .uop_hist(uop_hist));

  initial forever #(CLK_P/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench-side window and credits
  int v[4], u[4], d[4], s[4], ld[4], st[4];
  int robf, regf, pool, lqf, sqf, cfgw;
  int schf[2];
  // model results
  int en, eu, ec, use_r, use_l, use_q;
  int use_s[2];
  int mst[6];
  int mh[5];

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic drive();
    for (int i = 0; i < 4; i++) begin
      slot_valid[i]          = v[i][0];
      slot_uops[i*3 +: 3]    = 3'(u[i]);
      slot_ndst[i*2 +: 2]    = 2'(d[i]);
      slot_sched[i]          = s[i][0];
      slot_load[i]           = ld[i][0];
      slot_store[i]          = st[i][0];
    end
    rob_free      = CW'(robf);
    reg_free      = CW'(regf);
    reg_pool_size = CW'(pool);
    lq_free       = CW'(lqf);
    sq_free       = CW'(sqf);
    sched_free    = {CW'(schf[1]), CW'(schf[0])};
    cfg_width     = 3'(cfgw);
  endtask

  // behavioural reference for one cycle
  task automatic model();
    int w;
    int fr, fb, fs, fl, fq, fg;
    w = (cfgw == 0) ? DEFW : ((cfgw > MAXW) ? MAXW : cfgw);
    en = 0; eu = 0; ec = 0; use_r = 0; use_l = 0; use_q = 0;
    use_s[0] = 0; use_s[1] = 0;
    for (int i = 0; i < 4; i++) begin
      if (v[i] == 0) break;
      fr = (pool != 0) && (use_r + d[i] > regf);
      fb = (eu + u[i] > robf);
      fs = (use_s[s[i]] + u[i] > schf[s[i]]);
      fl = (ld[i] != 0) && (use_l + 1 > lqf);
      fq = (st[i] != 0) && (use_q + 1 > sqf);
      fg = (eu != 0) && (eu + u[i] > w);
      if (fr)      ec = 1;
      else if (fb) ec = 2;
      else if (fs) ec = 3;
      else if (fl) ec = 4;
      else if (fq) ec = 5;
      else if (fg) ec = 6;
      if (ec != 0) break;
      en++; eu += u[i]; use_r += d[i]; use_s[s[i]] += u[i];
      use_l += ld[i]; use_q += st[i];
    end
    if (eu >= w) ec = 0;
  endtask

  task automatic check_counters(input string tag);
    for (int c = 0; c < 6; c++)
      chk({tag, " R7 stall counter"}, int'(stall_cnt[c*CNTW +: CNTW]), mst[c]);
    for (int b = 0; b < 5; b++)
      chk({tag, " R8 histogram"}, int'(uop_hist[b*CNTW +: CNTW]), mh[b]);
  endtask

  // one cycle: drive at negedge, judge before posedge, account at posedge
  task automatic step(input string tag);
    drive();
    #1;
    model();
    chk({tag, " strobes"}, int'(disp_vec), (1 << en) - 1);
    chk({tag, " count"}, int'(disp_cnt), en);
    chk({tag, " uops"}, int'(disp_uops), eu);
    chk({tag, " R6 cause"}, int'(stall_cause), ec);
    check_counters(tag);
    @(posedge clk);
    if (ec != 0) mst[ec-1]++;
    mh[(eu >= MAXW) ? MAXW : eu]++;
    @(negedge clk);
  endtask

  task automatic plenty();
    robf = 63; regf = 63; pool = 63; lqf = 63; sqf = 63;
    schf[0] = 63; schf[1] = 63; cfgw = 4;
    for (int i = 0; i < 4; i++) begin
      v[i] = 1; u[i] = 1; d[i] = 1; s[i] = 0; ld[i] = 0; st[i] = 0;
    end
  endtask

  task automatic rand_slot(input int i);
    v[i]  = ($urandom_range(0, 7) != 0);
    u[i]  = ($urandom_range(0, 15) == 0) ? 5 : $urandom_range(1, 3);
    d[i]  = $urandom_range(0, 2);
    s[i]  = $urandom_range(0, 1);
    ld[i] = ($urandom_range(0, 3) == 0);
    st[i] = (ld[i] == 0) && ($urandom_range(0, 3) == 0);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: got hung run expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 6; c++) mst[c] = 0;
    for (int b = 0; b < 5; b++) mh[b] = 0;
    plenty();
    rst_n = 1'b0;
    drive();
    repeat (3) @(negedge clk);
    #1;
    check_counters("R10 reset");
    @(negedge clk);
    rst_n = 1'b1;

    plenty(); cfgw = 0;            step("R9 zero width picks default");
    plenty(); cfgw = 3;            step("R9 width three");
    plenty(); cfgw = 7;            step("R9 width clamp");
    plenty(); u[0] = 2; u[1] = 3;  step("R2 group limit");
    plenty(); cfgw = 2; u[0] = 5;  step("R2 oversize alone");
    plenty(); cfgw = 1; u[0] = 7; u[1] = 1; step("R2 oversize width one");
    plenty(); robf = 2;            step("R3 rob short");
    plenty(); regf = 1;            step("R4 reg short");
    plenty(); pool = 0; regf = 0; d[0] = 2; d[1] = 2; d[2] = 2; d[3] = 2;
                                   step("R4 unbounded pool ignores free");
    plenty(); regf = 0; robf = 0;  step("R6 reg over rob");
    plenty(); robf = 0; schf[0] = 0; step("R6 rob over sched");
    plenty(); cfgw = 2; u[1] = 2; robf = 1; d[1] = 0;
                                   step("R6 credit over group");
    plenty(); s[1] = 1; s[2] = 1; schf[1] = 1; step("R5 sched full");
    plenty(); ld[0] = 1; st[0] = 1; lqf = 0; sqf = 0; step("R5 load over store");
    plenty(); st[0] = 1; st[1] = 1; sqf = 1; step("R5 store queue");
    plenty(); ld[1] = 1; ld[2] = 1; lqf = 1; step("R5 load queue");
    plenty(); d[0] = 2; d[1] = 0; regf = 1; step("R1 older blocks younger");
    plenty(); v[1] = 0;            step("R1 hole ends group");
    plenty(); for (int i = 0; i < 4; i++) v[i] = 0; step("R6 empty window");

    // random stream against credit-counter pools
    plenty();
    robf = ROB_CAP; regf = REG_CAP; pool = REG_CAP; lqf = LQ_CAP; sqf = SQ_CAP;
    schf[0] = SCH_CAP; schf[1] = SCH_CAP;
    for (int i = 0; i < 4; i++) rand_slot(i);
    for (int cyc = 0; cyc < 3000; cyc++) begin
      if (cyc % 200 == 0) cfgw = $urandom_range(0, 5);
      pool = ((cyc / 500) % 2 == 1) ? 0 : REG_CAP;
      step("R1/R2/R3/R4/R5 random stream");
      robf -= eu;
      if (pool != 0) regf -= use_r;
      schf[0] -= use_s[0]; schf[1] -= use_s[1];
      lqf -= use_l; sqf -= use_q;
      robf += $urandom_range(0, ROB_CAP - robf);
      regf += $urandom_range(0, (regf < REG_CAP) ? REG_CAP - regf : 0);
      schf[0] += $urandom_range(0, SCH_CAP - schf[0]);
      schf[1] += $urandom_range(0, SCH_CAP - schf[1]);
      lqf += $urandom_range(0, LQ_CAP - lqf);
      sqf += $urandom_range(0, SQ_CAP - sqf);
      for (int i = 0; i < 4; i++) begin
        if (i + en < 4) begin
          v[i] = v[i+en]; u[i] = u[i+en]; d[i] = d[i+en];
          s[i] = s[i+en]; ld[i] = ld[i+en]; st[i] = st[i+en];
        end else begin
          rand_slot(i);
        end
      end
    end
    #1;
    check_counters("final");
    done = 1;
    summary();
    $finish;
  end

endmodule